// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. Each frame carries one extra bit after the data. Software sets this bit to tag the frame as a station address (1) or as ordinary data (0). A receiving station can then ignore the data frames that are meant for other stations. The rate of the line comes from an external baud tick, and each bit lasts a fixed number of ticks.

A host puts a byte into a holding register and then clears the empty flag. Clearing the flag commits the byte, together with the current address/data control bit. A DMA engine can instead answer the data-empty request. A DMA write both loads the byte and commits it, so no separate clear is needed. When the transmitter is switched on, the line first stays high for a full frame time before any data is sent. When it is switched off, the line is handed to a general-purpose port. Driving that port low holds the line in a break.

Top module: `mp_uart_tx`

## Requirements
- R1: After `txEnable` goes from 0 to 1, `txPin` stays 1 for one whole frame time (11 bits of 16 ticks) before any start bit. This holds even if data is already committed.
- R2: A `hostDataWr` pulse loads `wrData` into the holding register only while `emptyFlag` is 1. A write while `emptyFlag` is 0 has no effect on the frame that is sent.
- R3: An `emptyClr` pulse while `emptyFlag` is 1 commits the held byte, and `emptyFlag` reads 0 in the next cycle.
- R4: A frame is sent in this order: a start bit 0, then the 8 data bits least significant first, then the address/data bit, then a stop bit 1. Each bit lasts 16 baud ticks.
- R5: The address/data bit of a frame is the value of `mpBitCtl` at commit time. Later changes to `mpBitCtl` do not alter that frame.
- R6: `emptyFlag` is 1 out of reset. When the transmitter is idle, it returns to 1 in the cycle after a commit, because the byte moves into the shift register then. `txReq` equals `emptyFlag`.
- R7: `endFlag` is 1 out of reset and clears on a commit. It sets when a stop bit ends with nothing pending. It never reads 1 while `emptyFlag` reads 0.
- R8: A `dmaWr` pulse while `emptyFlag` is 1 loads `wrData` and commits it with the current `mpBitCtl`. `emptyFlag` reads 0 in the next cycle.
- R9: If a byte is committed before the current stop bit ends, its start bit follows that stop bit with no idle time.
- R10: While `txEnable` is 0, `txPin` equals `portData` if `portDir` is 1, and 1 otherwise. Clearing `txEnable` in the middle of a frame hands the pin over in the same cycle and drops the frame. `endFlag` then reads 1.
- R11: While `txEnable` is 0, committed data stays pending and is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One pulse per sixteenth of a bit |
| txEnable | input | 1 | Transmitter on; when 0 the port controls the pin |
| wrData | input | 8 | Byte for host or DMA writes |
| hostDataWr | input | 1 | Host write strobe for the holding register |
| emptyClr | input | 1 | Host clear of the empty flag (commit) |
| mpBitCtl | input | 1 | Address (1) / data (0) tag for the next commit |
| dmaWr | input | 1 | DMA write: load and commit |
| portDir | input | 1 | Port drives the pin when 1 |
| portData | input | 1 | Port output level |
| txPin | output | 1 | Serial line |
| emptyFlag | output | 1 | Holding register free |
| endFlag | output | 1 | All frames finished |
| txReq | output | 1 | Data-empty request to DMA |

## Verification
The flag results come one register after their cause. `emptyFlag` and `endFlag` change at the commit edge, so the bench samples them at the next falling edge. The move of the byte into the shift register comes one edge later, so the bench checks `emptyFlag` again one cycle after that. Line timing is measured from the detected falling edge of each start bit. The first sample is taken 16 cycles later, in the middle of the start bit, because a tick arrives every second cycle. After that the bench samples every 32 cycles, so a skew of one cycle at the start does not matter. Pin handover on disable is combinational, and the bench reads it shortly after changing `txEnable`, before the next clock edge.

// File: rtl/mp_uart_tx_pkg.sv
package mp_uart_tx_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // move holding register into shift register
    logic shift;    // advance to next bit
    logic done;     // last stop bit ended with nothing pending
    logic sending;  // shift register owns the line
  } txStrobes_t;
endpackage

// File: rtl/mp_uart_tx_ctrl.sv
module mp_uart_tx_ctrl
  import mp_uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_BITS    = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       baudTick,
  input  logic       dataPending,
  output txStrobes_t strb
);
  localparam int TW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {S_OFF, S_PRE, S_IDLE, S_SEND} state_t;
  state_t state;
  logic [TW-1:0] tickCnt;
  logic [BW-1:0] bitCnt;
  logic bitEnd, frameEnd;

  assign bitEnd   = baudTick && (tickCnt == TW'(TICKS_PER_BIT - 1));
  assign frameEnd = bitEnd && (bitCnt == BW'(FRAME_BITS - 1));

  always_comb begin
    strb = '0;
    if (txEnable) begin
      case (state)
        S_IDLE: strb.load = dataPending;
        S_SEND: begin
          strb.sending = 1'b1;
          if (frameEnd) begin
            strb.load = dataPending;
            strb.done = !dataPending;
          end else begin
            strb.shift = bitEnd;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_OFF;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!txEnable) begin
      state <= S_OFF;
    end else begin
      case (state)
        S_OFF: begin
          state   <= S_PRE;
          tickCnt <= '0;
          bitCnt  <= '0;
        end
        S_PRE, S_SEND: begin
          if (strb.load) begin
            tickCnt <= '0;
            bitCnt  <= '0;
          end else if (frameEnd) begin
            state <= S_IDLE;
          end else if (bitEnd) begin
            tickCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (strb.load) begin
            state   <= S_SEND;
            tickCnt <= '0;
            bitCnt  <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/mp_uart_tx_dp.sv
module mp_uart_tx_dp
  import mp_uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txEnable,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 hostDataWr,
  input  logic                 emptyClr,
  input  logic                 mpBitCtl,
  input  logic                 dmaWr,
  input  logic                 portDir,
  input  logic                 portData,
  input  txStrobes_t           strb,
  output logic                 txPin,
  output logic                 emptyFlag,
  output logic                 endFlag,
  output logic                 dataPending
);
  localparam int FW = DATA_BITS + 3;

  logic [DATA_BITS-1:0] dataReg;
  logic                 mpPend;
  logic [FW-1:0]        shiftReg;
  logic                 wrOk, commit;

  assign wrOk   = emptyFlag && (hostDataWr || dmaWr);
  assign commit = emptyFlag && (emptyClr || dmaWr);
  assign dataPending = !emptyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      mpPend    <= 1'b0;
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
      shiftReg  <= '1;
    end else begin
      if (wrOk) dataReg <= wrData;
      if (commit) begin
        emptyFlag <= 1'b0;
        mpPend    <= mpBitCtl;
      end else if (strb.load) begin
        emptyFlag <= 1'b1;
      end
      if (strb.load)       shiftReg <= {1'b1, mpPend, dataReg, 1'b0};
      else if (strb.shift) shiftReg <= {1'b1, shiftReg[FW-1:1]};
      if (commit)                                    endFlag <= 1'b0;
      else if (strb.done || (!txEnable && emptyFlag)) endFlag <= 1'b1;
    end
  end

  always_comb begin
    if (!txEnable)         txPin = portDir ? portData : 1'b1;
    else if (strb.sending) txPin = shiftReg[0];
    else                   txPin = 1'b1;
  end
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_tx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 txEnable,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 hostDataWr,
  input  logic                 emptyClr,
  input  logic                 mpBitCtl,
  input  logic                 dmaWr,
  input  logic                 portDir,
  input  logic                 portData,
  output logic                 txPin,
  output logic                 emptyFlag,
  output logic                 endFlag,
  output logic                 txReq
);
  localparam int FRAME_BITS = DATA_BITS + 3;

  txStrobes_t strb;
  logic       dataPending;

  mp_uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .dataPending(dataPending), .strb(strb)
  );

  mp_uart_tx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrData(wrData),
    .hostDataWr(hostDataWr), .emptyClr(emptyClr), .mpBitCtl(mpBitCtl),
    .dmaWr(dmaWr), .portDir(portDir), .portData(portData), .strb(strb),
    .txPin(txPin), .emptyFlag(emptyFlag), .endFlag(endFlag),
    .dataPending(dataPending)
  );

  assign txReq = emptyFlag;
endmodule

// File: rtl/mp_uart_tx_chk.sv
module mp_uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic emptyClr,
  input logic dmaWr,
  input logic txPin,
  input logic emptyFlag,
  input logic endFlag
);
  p_idle_high_after_enable_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |=> txPin);

  p_clear_commits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && emptyClr) |=> (!emptyFlag && !endFlag));

  p_dma_commits_r8: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && dmaWr) |=> !emptyFlag);

  p_end_needs_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    endFlag |-> emptyFlag);

  p_hold_while_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !emptyFlag) |=> !emptyFlag);
endmodule

bind mp_uart_tx mp_uart_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .emptyClr(emptyClr),
  .dmaWr(dmaWr), .txPin(txPin), .emptyFlag(emptyFlag), .endFlag(endFlag)
);

// File: tb/mp_uart_tx_tb.sv
module mp_uart_tx_tb;
  localparam int BIT_CYC = 32; // 16 ticks, one tick every 2 cycles

  logic clk = 0, rstN = 0, baudTick = 0, txEnable = 0;
  logic [7:0] wrData = 0;
  logic hostDataWr = 0, emptyClr = 0, mpBitCtl = 0, dmaWr = 0;
  logic portDir = 0, portData = 0;
  logic txPin, emptyFlag, endFlag, txReq;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  always @(negedge clk) baudTick <= ~baudTick;

  mp_uart_tx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .wrData(wrData), .hostDataWr(hostDataWr), .emptyClr(emptyClr),
    .mpBitCtl(mpBitCtl), .dmaWr(dmaWr), .portDir(portDir), .portData(portData),
    .txPin(txPin), .emptyFlag(emptyFlag), .endFlag(endFlag), .txReq(txReq)
  );

  // {dma, mp, data}
  localparam logic [9:0] VEC [0:5] = '{10'h155, 10'h2C3, 10'h000, 10'h3FF, 10'h180, 10'h201};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frameOf(input logic [7:0] d, input logic mp);
    return {1'b1, mp, d, 1'b0};
  endfunction

  task automatic commitHost(input logic [7:0] d, input logic mp);
    @(negedge clk); hostDataWr = 1; wrData = d;
    @(negedge clk); hostDataWr = 0; emptyClr = 1; mpBitCtl = mp;
    @(negedge clk); emptyClr = 0;
  endtask

  task automatic commitDma(input logic [7:0] d, input logic mp);
    @(negedge clk); dmaWr = 1; wrData = d; mpBitCtl = mp;
    @(negedge clk); dmaWr = 0;
  endtask

  task automatic waitFall(input int lim, output int cyc);
    cyc = 0;
    while (txPin !== 1'b0 && cyc < lim) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= lim) cyc = -1;
  endtask

  task automatic sampleFrame(output logic [10:0] b);
    repeat (BIT_CYC / 2) @(negedge clk);
    b[0] = txPin;
    for (int i = 1; i < 11; i++) begin
      repeat (BIT_CYC) @(negedge clk);
      b[i] = txPin;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [10:0] fr;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R6 reset empty", emptyFlag, 1);
    chk("R6 reset req", txReq, 1);
    chk("R7 reset end", endFlag, 1);
    chk("R10 reset pin", txPin, 1);

    // R11 / R2 / R5: commit while disabled, then disturb
    commitHost(8'hA5, 1'b1);
    chk("R3 empty after clear", emptyFlag, 0);
    repeat (50) @(negedge clk);
    chk("R11 pending held while off", emptyFlag, 0);
    chk("R11 pin idle while off", txPin, 1);
    mpBitCtl = 0;
    hostDataWr = 1; wrData = 8'h3C;
    @(negedge clk); hostDataWr = 0;

    // R1: preamble
    txEnable = 1;
    waitFall(1000, cyc);
    checks++;
    if (cyc < 350 || cyc > 360) begin
      errors++;
      $display("FAIL R1 preamble cycles actual=%0d expected=350..360", cyc);
    end
    sampleFrame(fr);
    chk("R4 R2 R5 first frame", fr, frameOf(8'hA5, 1'b1));
    chk("R7 end low mid stop", endFlag, 0);
    repeat (24) @(negedge clk);
    chk("R7 end after stop", endFlag, 1);

    // table of frames
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][9]) commitDma(VEC[v][7:0], VEC[v][8]);
      else           commitHost(VEC[v][7:0], VEC[v][8]);
      chk(VEC[v][9] ? "R8 dma commit" : "R3 host commit", emptyFlag, 0);
      @(negedge clk);
      chk("R6 empty after load", emptyFlag, 1);
      chk("R6 req follows empty", txReq, 1);
      mpBitCtl = ~VEC[v][8];
      waitFall(40, cyc);
      sampleFrame(fr);
      chk("R4 frame", fr, frameOf(VEC[v][7:0], VEC[v][8]));
      repeat (24) @(negedge clk);
      chk("R7 end set", endFlag, 1);
    end

    // R9: back to back
    commitHost(8'h81, 1'b0);
    waitFall(40, cyc);
    commitHost(8'h7E, 1'b1);
    sampleFrame(fr);
    chk("R9 first of pair", fr, frameOf(8'h81, 1'b0));
    chk("R7 end low while pending", endFlag, 0);
    waitFall(100, cyc);
    checks++;
    if (cyc < 0 || cyc > 18) begin
      errors++;
      $display("FAIL R9 gap actual=%0d expected=<=18", cyc);
    end
    sampleFrame(fr);
    chk("R9 second of pair", fr, frameOf(8'h7E, 1'b1));
    repeat (24) @(negedge clk);

    // R10: abandon mid frame, break
    commitHost(8'hFF, 1'b0);
    waitFall(40, cyc);
    repeat (40) @(negedge clk);
    chk("R10 pin high in data", txPin, 1);
    portDir = 1; portData = 0; txEnable = 0;
    #1 chk("R10 break low", txPin, 0);
    repeat (2) @(negedge clk);
    chk("R10 end after abandon", endFlag, 1);
    portData = 1;
    #1 chk("R10 port high", txPin, 1);
    portDir = 0; portData = 0;
    #1 chk("R10 released", txPin, 1);
    @(negedge clk);
    txEnable = 1;
    waitFall(500, cyc);
    chk("R10 no resend after abandon", cyc, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule